// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches the two ports of a synchronous dual-port memory wrapper, called left and right. Each clock it samples both ports' enables and addresses. When both ports are enabled on the same address it decides which of them owns that location and pulls an active-low busy flag on the other one. The port that got to the location first keeps it. Ownership is set by the first cycle of the match, and the later port, or the right port on a same-cycle tie, is flagged.

A mode input selects between two roles. As a master, the block drives its busy flags from its own decision. As a slave, a separate set of busy inputs carries the decision of an external master, and each port's write strobe toward the array is blocked while that port's busy input is low. This lets several devices be ganged into a wider word with a single arbitration point. In both modes, the block passes each port's write strobe to the array on its write-permit output.

Top module: `contention_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, both busy outputs are high (inactive).
- R2: A contention exists only when both enables are high and the two addresses are equal. Without one, both busy outputs are high one clock after the inputs are sampled.
- R3: If the right port moves onto an address the enabled left port already held in the previous cycle, busy_r_n_o goes low and busy_l_n_o stays high one clock later.
- R4: If the left port moves onto an address the enabled right port already held, or re-enables on it, busy_l_n_o goes low and busy_r_n_o stays high one clock later.
- R5: If both ports arrive at a matching address in the same cycle, the left port wins: busy_r_n_o low, busy_l_n_o high.
- R6: The two busy outputs are never low together.
- R7: While the match persists, the winner keeps ownership and the busy output of the losing port stays low, whatever the loser does with its write strobe.
- R8: Busy is released one clock after the addresses stop matching or either enable drops.
- R9: With is_master_i low (slave), both busy outputs are high, whatever the contention.
- R10: In slave mode, a port's write permit is low while its busy input is low. It equals enable AND write strobe while its busy input is high.
- R11: In master mode, a port's write permit equals enable AND write strobe, and the busy inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master_i | input | 1 | 1 = master (busy generated here), 0 = slave (busy taken from inputs) |
| l_en_i | input | 1 | Left port enable |
| l_addr_i | input | AW (12) | Left port address |
| l_we_i | input | 1 | Left port write strobe |
| r_en_i | input | 1 | Right port enable |
| r_addr_i | input | AW (12) | Right port address |
| r_we_i | input | 1 | Right port write strobe |
| busy_l_n_i | input | 1 | Left busy from external master, active low (slave mode) |
| busy_r_n_i | input | 1 | Right busy from external master, active low (slave mode) |
| busy_l_n_o | output | 1 | Left busy flag, active low |
| busy_r_n_o | output | 1 | Right busy flag, active low |
| l_wr_ok_o | output | 1 | Left write permitted to reach the array |
| r_wr_ok_o | output | 1 | Right write permitted to reach the array |

## Verification
The hardest case to reach from the ports is a port arriving second on a match that the other port formed earlier, without passing through a tie. The stimulus covers this in two ways. It holds one port steady on an address for a cycle before the other moves onto it. It also drops one enable and raises it again on the same address, so that the re-enabled port is the late arrival. The persistence check keeps the match alive for several cycles after it forms while the loser toggles its write strobe, and confirms that ownership does not move.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // Which port currently owns a contended location
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NPORTS  = 2;
    localparam int P_LEFT  = 0;
    localparam int P_RIGHT = 1;
endpackage

// File: rtl/port_tracker.sv
// port_tracker: remembers one port's previous enable and address and reports
// whether the port is presenting the same enabled address as last cycle.
// Assumes inputs are synchronous to clk.
module port_tracker #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    output logic          stable_o
);
    logic          prev_en_q;
    logic [AW-1:0] prev_addr_q;

    // Capture this cycle's enable and address for comparison next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_en_q   <= en_i;
            prev_addr_q <= addr_i;
        end
    end

    // Port held the same enabled address across two samples
    always_comb begin
        stable_o = prev_en_q && en_i && (prev_addr_q == addr_i);
    end
endmodule

// File: rtl/owner_fsm.sv
// owner_fsm: registers which port owns the contended location.
// A new match goes to the port that was already there, and to the left
// port when both arrived together. Ownership holds while the match lasts.
module owner_fsm
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match_i,
    input  logic   stable_l_i,
    input  logic   stable_r_i,
    output owner_e owner_o
);
    owner_e owner_q;
    owner_e owner_d;

    // Choose next owner from match and arrival order
    always_comb begin
        if (!match_i)
            owner_d = OWN_NONE;
        else if (owner_q != OWN_NONE)
            owner_d = owner_q;
        else if (stable_r_i && !stable_l_i)
            owner_d = OWN_RIGHT;
        else
            owner_d = OWN_LEFT;
    end

    // Ownership register
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    assign owner_o = owner_q;

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_i |=> owner_q == OWN_NONE);

    // R7
    hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_LEFT && match_i) |=> owner_q == OWN_LEFT);

    // R7
    hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_RIGHT && match_i) |=> owner_q == OWN_RIGHT);

    // R3
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_NONE && match_i && stable_l_i && !stable_r_i)
        |=> owner_q == OWN_LEFT);
endmodule

// File: rtl/write_gate.sv
// write_gate: forwards one port's write strobe to the array. In slave mode
// the strobe is suppressed while the external busy input is low.
module write_gate (
    input  logic is_master_i,
    input  logic en_i,
    input  logic we_i,
    input  logic busy_n_i,
    output logic wr_ok_o
);
    // Combine strobe, enable and (slave only) external busy
    always_comb begin
        wr_ok_o = en_i && we_i && (is_master_i || busy_n_i);
    end
endmodule

// File: rtl/contention_arbiter.sv
// contention_arbiter: top level. Detects same-address access from both
// ports, keeps first-come ownership and drives active-low busy flags
// (master) or takes busy from outside and gates writes (slave).
// Assumes both ports share clk; busy outputs lag input changes by one clock.
module contention_arbiter
    import arb_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master_i,
    input  logic          l_en_i,
    input  logic [AW-1:0] l_addr_i,
    input  logic          l_we_i,
    input  logic          r_en_i,
    input  logic [AW-1:0] r_addr_i,
    input  logic          r_we_i,
    input  logic          busy_l_n_i,
    input  logic          busy_r_n_i,
    output logic          busy_l_n_o,
    output logic          busy_r_n_o,
    output logic          l_wr_ok_o,
    output logic          r_wr_ok_o
);
    logic [NPORTS-1:0] en_v;
    logic [NPORTS-1:0] we_v;
    logic [NPORTS-1:0] bin_v;
    logic [NPORTS-1:0] stable_v;
    logic [NPORTS-1:0] wr_ok_v;
    logic [AW-1:0]     addr_v [NPORTS];
    logic              match;
    owner_e            owner;

    // Gather per-port inputs into arrays
    always_comb begin
        en_v[P_LEFT]    = l_en_i;
        en_v[P_RIGHT]   = r_en_i;
        we_v[P_LEFT]    = l_we_i;
        we_v[P_RIGHT]   = r_we_i;
        bin_v[P_LEFT]   = busy_l_n_i;
        bin_v[P_RIGHT]  = busy_r_n_i;
        addr_v[P_LEFT]  = l_addr_i;
        addr_v[P_RIGHT] = r_addr_i;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        port_tracker #(.AW(AW)) i_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_v[p]),
            .addr_i   (addr_v[p]),
            .stable_o (stable_v[p])
        );
        write_gate i_wg (
            .is_master_i (is_master_i),
            .en_i        (en_v[p]),
            .we_i        (we_v[p]),
            .busy_n_i    (bin_v[p]),
            .wr_ok_o     (wr_ok_v[p])
        );
    end

    // Contention: both enabled on one address
    always_comb begin
        match = en_v[P_LEFT] && en_v[P_RIGHT] &&
                (addr_v[P_LEFT] == addr_v[P_RIGHT]);
    end

    owner_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_i    (match),
        .stable_l_i (stable_v[P_LEFT]),
        .stable_r_i (stable_v[P_RIGHT]),
        .owner_o    (owner)
    );

    // Busy flags: loser low in master mode, idle high in slave mode
    always_comb begin
        busy_l_n_o = !(is_master_i && owner == OWN_RIGHT);
        busy_r_n_o = !(is_master_i && owner == OWN_LEFT);
    end

    assign l_wr_ok_o = wr_ok_v[P_LEFT];
    assign r_wr_ok_o = wr_ok_v[P_RIGHT];

    // R6
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_l_n_o || busy_r_n_o);

    // R10
    slave_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master_i && !busy_l_n_i) |-> !l_wr_ok_o);
endmodule

// File: tb/test_contention_arbiter.sv
module test_contention_arbiter;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master_i = 1'b1;
    logic          l_en_i = 1'b0, r_en_i = 1'b0;
    logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
    logic          l_we_i = 1'b0, r_we_i = 1'b0;
    logic          busy_l_n_i = 1'b1, busy_r_n_i = 1'b1;
    logic          busy_l_n_o, busy_r_n_o, l_wr_ok_o, r_wr_ok_o;

    int tests  = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int    due;
        logic  exp_l;
        logic  exp_r;
        string req;
    } item_t;
    item_t sb_q [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    contention_arbiter #(.AW(AW)) i_contention_arbiter (
        .clk(clk), .rst_n(rst_n), .is_master_i(is_master_i),
        .l_en_i(l_en_i), .l_addr_i(l_addr_i), .l_we_i(l_we_i),
        .r_en_i(r_en_i), .r_addr_i(r_addr_i), .r_we_i(r_we_i),
        .busy_l_n_i(busy_l_n_i), .busy_r_n_i(busy_r_n_i),
        .busy_l_n_o(busy_l_n_o), .busy_r_n_o(busy_r_n_o),
        .l_wr_ok_o(l_wr_ok_o), .r_wr_ok_o(r_wr_ok_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of port inputs at negedge and queues expected busy
    task automatic step(input logic le, input int la, input logic lw,
                        input logic re, input int ra, input logic rw,
                        input logic el, input logic er, input string req);
        @(negedge clk);
        l_en_i = le; l_addr_i = AW'(la); l_we_i = lw;
        r_en_i = re; r_addr_i = AW'(ra); r_we_i = rw;
        sb_q.push_back('{due: cyc + 1, exp_l: el, exp_r: er, req: req});
    endtask

    // Monitor: compares queued expectations one clock after their stimulus
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, busy_l_n_o, it.exp_l, "busy_l_n_o");
            check(it.req, busy_r_n_o, it.exp_r, "busy_r_n_o");
        end
    end

    task automatic drain;
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", busy_l_n_o, 1'b1, "busy_l_n_o in reset");
        check("R1", busy_r_n_o, 1'b1, "busy_r_n_o in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", busy_l_n_o & busy_r_n_o, 1'b1, "busy after reset");

        // Master mode sequences
        step(1, 5, 0, 0, 5, 0, 1, 1, "R2");   // right disabled
        step(1, 5, 0, 1, 7, 0, 1, 1, "R2");   // addresses differ
        step(1, 5, 0, 1, 5, 0, 1, 0, "R3");   // right joins left's address
        step(1, 5, 0, 1, 5, 0, 1, 0, "R7");
        step(1, 5, 0, 1, 5, 1, 1, 0, "R7");   // loser writes, still loses
        drain();
        #1 check("R11", r_wr_ok_o, 1'b1, "master write passes");
        step(1, 5, 0, 1, 5, 0, 1, 0, "R7");
        step(1, 5, 0, 1, 6, 0, 1, 1, "R8");   // mismatch releases
        step(1, 6, 0, 1, 6, 0, 0, 1, "R4");   // left joins right's address
        step(1, 6, 0, 1, 6, 0, 0, 1, "R7");
        step(1, 6, 0, 0, 6, 0, 1, 1, "R8");   // right enable drops
        step(0, 9, 0, 0, 9, 0, 1, 1, "R2");
        step(1, 9, 0, 1, 9, 0, 1, 0, "R5");   // simultaneous arrival
        step(1, 9, 0, 1, 9, 0, 1, 0, "R7");
        step(0, 9, 0, 1, 9, 0, 1, 1, "R8");   // left enable drops
        step(1, 9, 0, 1, 9, 0, 0, 1, "R4");   // left re-enables, arrives late
        step(1, 9, 1, 1, 9, 0, 0, 1, "R7");
        step(1, 9, 0, 1, 9, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 1, "R8");
        step(1, 4095, 0, 1, 0, 0, 1, 1, "R2");
        step(1, 4095, 0, 1, 4095, 0, 1, 0, "R3");
        drain();

        // R11: busy inputs ignored in master mode
        @(negedge clk);
        busy_l_n_i = 1'b0; l_we_i = 1'b1; l_en_i = 1'b1;
        #1 check("R11", l_wr_ok_o, 1'b1, "master ignores busy input");

        // Slave mode: R9 busy outputs idle despite contention
        is_master_i = 1'b0;
        step(1, 3, 1, 1, 3, 0, 1, 1, "R9");
        step(1, 3, 1, 1, 3, 0, 1, 1, "R9");
        drain();
        // R10: write blocked by busy input, passes when released
        #1 check("R10", l_wr_ok_o, 1'b0, "slave write with busy low");
        busy_l_n_i = 1'b1;
        #1 check("R10", l_wr_ok_o, 1'b1, "slave write with busy high");
        busy_r_n_i = 1'b0; r_we_i = 1'b1;
        #1 check("R10", r_wr_ok_o, 1'b0, "slave right write with busy low");
        busy_r_n_i = 1'b1;
        #1 check("R10", r_wr_ok_o, 1'b1, "slave right write with busy high");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule